// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and presents the most urgent one to a processor. Software programs it through a two-address byte port: one address is the command port, the other the data port, and separate write and read strobes qualify each access. A four-word start-up sequence sets the vector base, stores a cascade configuration byte and selects the end-of-interrupt style. After that, command bytes pick which status register the command port returns and retire serviced levels one by one.

Requests are ranked with line 0 most urgent. A request is offered to the processor only if it is unmasked and outranks every level still in service. The processor answers the interrupt output with a one-cycle acknowledge pulse and receives an 8-bit vector on the following cycle. If the request has gone away by the time the acknowledge arrives, the block still answers, with the vector of the lowest-priority line and no change to the in-service state. This happens even when that line is masked.

Top module: `prio_intc`

## Requirements
- R1: After reset the request and in-service registers are zero, the mask register reads 0xFF, command-port reads return the request register, int_out is low and casc_word is 0x00.
- R2: A command-port write with bit 4 set, for example 0x11, starts initialization and clears the in-service register. The next three data-port writes are taken as vector base, cascade byte and mode byte, in that order. int_out stays low from reset until this sequence completes, and again from a restart until it completes.
- R3: The vector delivered for line n is the vector base plus n. For example, a base of 0x30 gives 0x30 to 0x37.
- R4: The cascade byte is stored as written and driven on casc_word.
- R5: Command byte 0x0A selects the request register and 0x0B selects the in-service register for later command-port reads. Starting initialization selects the request register. Read data appears on rd_data one cycle after the read strobe.
- R6: A data-port write made outside the three-word sequence loads the mask register, and a data-port read returns it. A masked line never raises int_out.
- R7: Priority is fixed with line 0 highest. A request is forwarded only if it is unmasked and has a lower line number than every set in-service bit.
- R8: An acknowledge while a request is forwarded clears that line's request bit and sets its in-service bit. vec_valid is high for the cycle after the acknowledge and vec_out holds the vector. int_out is low in that cycle and then follows the remaining requests.
- R9: Command byte 0x60+n clears in-service bit n and no other bit.
- R10: When bit 1 of the mode byte is set (automatic end of interrupt), an acknowledge sets no in-service bit.
- R11: An acknowledge while no request is forwarded returns vector base plus 7 and leaves the in-service register unchanged, even when line 7 is masked.
- R12: In edge mode (irq_level bit low) a low-to-high transition sets the request bit, which clears if the line falls before acknowledge. A line held high after its acknowledge makes no new request. In level mode the request bit follows the line while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe; data appears on the next cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_lines | input | 8 | Interrupt request lines |
| irq_level | input | 8 | Per-line trigger select: 1 level, 0 rising edge |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Single-cycle acknowledge from the processor |
| vec_valid | output | 1 | High for the cycle after an acknowledge |
| vec_out | output | 8 | Delivered vector |
| casc_word | output | 8 | Stored cascade configuration byte |

## Verification
The bench builds the block with its default parameters: eight lines and an 8-bit port. At this size every line can be swept on its own and every ordered pair of lines can be tried, raised together or nested. This puts each priority relation, each in-service blocking case and each single-level end-of-interrupt within reach. The same small setting makes it practical to run the full sweep both with normal end of interrupt and with automatic end of interrupt, and to test masking and spurious delivery for each line.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_BASE,
    SQ_CASC,
    SQ_MODE,
    SQ_READY
  } seq_e;

  localparam int          INIT_FLAG_BIT = 4;
  localparam logic [7:0]  OP_SEL_REQ    = 8'h0A;
  localparam logic [7:0]  OP_SEL_SVC    = 8'h0B;
  localparam logic [4:0]  OP_EOI_TAG    = 5'b01100;
  localparam int          AEOI_BIT      = 1;
endpackage

// File: rtl/intc_prog.sv
module intc_prog
  import intc_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          sel_data,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  mask_q,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] casc_q,
  output logic          aeoi_q,
  output logic          show_svc_q,
  output logic          ready,
  output logic          init_start,
  output logic          eoi_hit,
  output logic [IW-1:0] eoi_idx
);
  seq_e          seq_q, seq_d;
  logic [N-1:0]  mask_d;
  logic [DW-1:0] base_d, casc_d;
  logic          aeoi_d, show_svc_d;

  assign ready   = (seq_q == SQ_READY);
  assign eoi_idx = wdata[IW-1:0];

  always_comb begin
    seq_d      = seq_q;
    mask_d     = mask_q;
    base_d     = base_q;
    casc_d     = casc_q;
    aeoi_d     = aeoi_q;
    show_svc_d = show_svc_q;
    init_start = 1'b0;
    eoi_hit    = 1'b0;
    if (wr_en && !sel_data) begin
      if (wdata[INIT_FLAG_BIT]) begin
        seq_d      = SQ_BASE;
        show_svc_d = 1'b0;
        init_start = 1'b1;
      end else if (wdata == OP_SEL_REQ) begin
        show_svc_d = 1'b0;
      end else if (wdata == OP_SEL_SVC) begin
        show_svc_d = 1'b1;
      end else if (wdata[7:3] == OP_EOI_TAG && 32'(wdata[2:0]) < N) begin
        eoi_hit = 1'b1;
      end
    end else if (wr_en && sel_data) begin
      case (seq_q)
        SQ_BASE: begin base_d = wdata; seq_d = SQ_CASC; end
        SQ_CASC: begin casc_d = wdata; seq_d = SQ_MODE; end
        SQ_MODE: begin aeoi_d = wdata[AEOI_BIT]; seq_d = SQ_READY; end
        default: mask_d = wdata[N-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SQ_IDLE;
      mask_q     <= '1;
      base_q     <= '0;
      casc_q     <= '0;
      aeoi_q     <= 1'b0;
      show_svc_q <= 1'b0;
    end else if (wr_en) begin
      seq_q      <= seq_d;
      mask_q     <= mask_d;
      base_q     <= base_d;
      casc_q     <= casc_d;
      aeoi_q     <= aeoi_d;
      show_svc_q <= show_svc_d;
    end
  end
endmodule

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic prev_q, req_q, req_d;

    always_comb begin
      if (level_i[g])
        req_d = line_i[g] & ~clr_i[g];
      else
        req_d = ((req_q & line_i[g]) | (line_i[g] & ~prev_q)) & ~clr_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        req_q  <= 1'b0;
      end else begin
        prev_q <= line_i[g];
        req_q  <= req_d;
      end
    end

    assign irr_o[g] = req_q;
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  svc_i,
  output logic          pending_o,
  output logic [IW-1:0] win_o
);
  logic [N-1:0] allowed, cand;
  logic         blocked;

  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      blocked    = blocked | svc_i[i];
      allowed[i] = ~blocked;
    end
    cand      = irr_i & ~mask_i & allowed;
    pending_o = |cand;
    win_o     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) win_o = IW'(i);
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [N-1:0]  irq_lines,
  input  logic [N-1:0]  irq_level,
  output logic          int_out,
  input  logic          int_ack,
  output logic          vec_valid,
  output logic [DW-1:0] vec_out,
  output logic [DW-1:0] casc_word
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [1:0]    rs_q;
  logic          rst_ns;
  logic [N-1:0]  mask_q, irr_q, isr_q, isr_d, clr_vec;
  logic [DW-1:0] base_q, vec_d, rd_d, off;
  logic          aeoi_q, show_svc_q, ready, init_start, eoi_hit;
  logic [IW-1:0] eoi_idx, win_idx;
  logic          pend_raw, pend_rdy, grant, int_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  intc_prog #(.N(N), .DW(DW), .IW(IW)) u_prog (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_stb), .sel_data(reg_sel),
    .wdata(wr_data), .mask_q(mask_q), .base_q(base_q), .casc_q(casc_word),
    .aeoi_q(aeoi_q), .show_svc_q(show_svc_q), .ready(ready),
    .init_start(init_start), .eoi_hit(eoi_hit), .eoi_idx(eoi_idx)
  );

  intc_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_ns), .line_i(irq_lines), .level_i(irq_level),
    .clr_i(clr_vec), .irr_o(irr_q)
  );

  intc_arbiter #(.N(N), .IW(IW)) u_arb (
    .irr_i(irr_q), .mask_i(mask_q), .svc_i(isr_q),
    .pending_o(pend_raw), .win_o(win_idx)
  );

  assign pend_rdy = pend_raw & ready;
  assign grant    = int_ack & pend_rdy;

  always_comb begin
    clr_vec = '0;
    if (grant) clr_vec = N'(1) << win_idx;

    isr_d = isr_q;
    if (init_start) begin
      isr_d = '0;
    end else begin
      if (eoi_hit)            isr_d[eoi_idx] = 1'b0;
      if (grant && !aeoi_q)   isr_d[win_idx] = 1'b1;
    end

    int_d = pend_rdy & ~int_ack;
    off   = grant ? DW'(win_idx) : DW'(N - 1);
    vec_d = base_q + off;

    if (reg_sel)         rd_d = DW'(mask_q);
    else if (show_svc_q) rd_d = DW'(isr_q);
    else                 rd_d = DW'(irr_q);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      isr_q     <= '0;
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      rd_data   <= '0;
    end else begin
      isr_q     <= isr_d;
      int_out   <= int_d;
      vec_valid <= int_ack;
      if (int_ack) vec_out <= vec_d;
      if (rd_stb)  rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_i,
  input logic          wr_stb,
  input logic          int_out,
  input logic          vec_valid,
  input logic [DW-1:0] vec_out,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  irr_q,
  input logic [N-1:0]  mask_q,
  input logic          pend,
  input logic [IW-1:0] win_idx,
  input logic [DW-1:0] base_q,
  input logic          aeoi_q,
  input logic          ready
);
  a_r2_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !int_out);

  a_r7_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (irr_q[win_idx] && !mask_q[win_idx]));

  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (!int_out && vec_valid));

  a_r8_svc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && pend && !aeoi_q && !wr_stb)
      |=> ((isr_q & ~$past(isr_q)) == (N'(1) << $past(win_idx))));

  a_r10_auto_no_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && pend && aeoi_q && !wr_stb) |=> $stable(isr_q));

  a_r11_spur_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !pend) |=> (vec_out == $past(base_q) + DW'(N - 1)));

  a_r11_spur_no_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !pend && !wr_stb) |=> $stable(isr_q));
endmodule

bind prio_intc intc_checker #(.N(N), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_ns), .ack_i(int_ack), .wr_stb(wr_stb),
  .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
  .isr_q(isr_q), .irr_q(irr_q), .mask_q(mask_q), .pend(pend_rdy),
  .win_idx(win_idx), .base_q(base_q), .aeoi_q(aeoi_q), .ready(ready)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, wr_stb, rd_stb, int_ack;
  logic [7:0] wr_data, rd_data, irq_lines, irq_level, vec_out, casc_word;
  logic       int_out, vec_valid;
  int         nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data),
    .irq_lines(irq_lines), .irq_level(irq_level), .int_out(int_out),
    .int_ack(int_ack), .vec_valid(vec_valid), .vec_out(vec_out),
    .casc_word(casc_word)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    reg_sel = a; wr_data = d; wr_stb = 1'b1;
    step();
    wr_stb = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    reg_sel = a; rd_stb = 1'b1;
    step();
    rd_stb = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_svc(output logic [7:0] d);
    wr_reg(1'b0, 8'h0B);
    rd_reg(1'b0, d);
  endtask

  task automatic do_ack(output logic [7:0] v);
    int_ack = 1'b1;
    step();
    int_ack = 1'b0;
    v = vec_out;
    chk("R8", "vec_valid after ack", 32'(vec_valid), 1);
    chk("R8", "int_out low after ack", 32'(int_out), 0);
  endtask

  initial begin
    #(8ns * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d, v;
    rst_n = 1'b0; reg_sel = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    int_ack = 1'b0; wr_data = '0; irq_lines = '0; irq_level = '0;
    step(3);
    chk("R1", "int_out in reset", 32'(int_out), 0);
    chk("R1", "casc_word in reset", 32'(casc_word), 0);
    rst_n = 1'b1;
    step(4);
    rd_reg(1'b1, d); chk("R1", "mask after reset", 32'(d), 32'hFF);
    rd_reg(1'b0, d); chk("R1", "cmd read is request reg", 32'(d), 0);
    rd_svc(d);       chk("R1", "in-service after reset", 32'(d), 0);
    wr_reg(1'b0, 8'h0A);

    // R2: before initialization nothing is forwarded
    wr_reg(1'b1, 8'h00);
    irq_lines[0] = 1'b1;
    step(3);
    chk("R2", "int_out before init", 32'(int_out), 0);
    irq_lines[0] = 1'b0;
    step(2);

    // initialization, normal end of interrupt
    wr_reg(1'b0, 8'h11);
    wr_reg(1'b1, 8'h30);
    wr_reg(1'b1, 8'h04);
    chk("R4", "cascade byte", 32'(casc_word), 32'h04);
    wr_reg(1'b1, 8'h01);
    rd_reg(1'b1, d); chk("R6", "mask kept across init", 32'(d), 0);

    // single-line sweep
    for (int n = 0; n < 8; n++) begin
      irq_lines[n] = 1'b1;
      step(2);
      chk("R12", "edge raises int_out", 32'(int_out), 1);
      do_ack(v);
      chk("R3", "vector base+n", 32'(v), 32'h30 + n);
      rd_svc(d);
      chk("R8", "in-service bit set", 32'(d), 32'(1 << n));
      wr_reg(1'b0, 8'h0A);
      rd_reg(1'b0, d);
      chk("R12", "request cleared by ack", 32'(d), 0);
      wr_reg(1'b0, 8'h60 + 8'(n));
      rd_svc(d);
      chk("R9", "eoi clears bit", 32'(d), 0);
      step(2);
      chk("R12", "held edge line no re-request", 32'(int_out), 0);
      irq_lines[n] = 1'b0;
      step(2);
    end

    // nested: lower-priority in service, higher one arrives
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        irq_lines[j] = 1'b1;
        step(2);
        do_ack(v);
        chk("R3", "nested first vector", 32'(v), 32'h30 + j);
        irq_lines[i] = 1'b1;
        step(2);
        chk("R7", "higher preempts in-service", 32'(int_out), 1);
        do_ack(v);
        chk("R7", "nested second vector", 32'(v), 32'h30 + i);
        wr_reg(1'b0, 8'h60 + 8'(i));
        rd_svc(d);
        chk("R9", "only level i cleared", 32'(d), 32'(1 << j));
        wr_reg(1'b0, 8'h60 + 8'(j));
        irq_lines = '0;
        step(2);
      end
    end

    // simultaneous pair: winner, then blocking, then the loser
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        irq_lines[i] = 1'b1;
        irq_lines[j] = 1'b1;
        step(2);
        do_ack(v);
        chk("R7", "pair winner", 32'(v), 32'h30 + i);
        step();
        chk("R7", "lower blocked by in-service", 32'(int_out), 0);
        wr_reg(1'b0, 8'h60 + 8'(i));
        step();
        chk("R7", "loser forwarded after eoi", 32'(int_out), 1);
        do_ack(v);
        chk("R7", "pair loser", 32'(v), 32'h30 + j);
        wr_reg(1'b0, 8'h60 + 8'(j));
        irq_lines = '0;
        step(2);
      end
    end

    // mask sweep
    for (int n = 0; n < 8; n++) begin
      wr_reg(1'b1, 8'(1 << n));
      irq_lines[n] = 1'b1;
      step(3);
      chk("R6", "masked line silent", 32'(int_out), 0);
      rd_reg(1'b1, d);
      chk("R6", "mask readback", 32'(d), 32'(1 << n));
      wr_reg(1'b1, 8'h00);
      step();
      chk("R6", "unmasked line forwarded", 32'(int_out), 1);
      do_ack(v);
      chk("R3", "vector after unmask", 32'(v), 32'h30 + n);
      wr_reg(1'b0, 8'h60 + 8'(n));
      irq_lines[n] = 1'b0;
      step(2);
    end

    // spurious delivery with line 7 masked
    wr_reg(1'b1, 8'h80);
    irq_lines[3] = 1'b1;
    step(2);
    irq_lines[3] = 1'b0;
    step();
    chk("R11", "int_out still high at withdraw", 32'(int_out), 1);
    do_ack(v);
    chk("R11", "spurious vector", 32'(v), 32'h37);
    rd_svc(d);
    chk("R11", "no in-service on spurious", 32'(d), 0);
    wr_reg(1'b0, 8'h0A);
    wr_reg(1'b1, 8'h00);

    // level mode
    irq_level[5] = 1'b1;
    irq_lines[5] = 1'b1;
    step(2);
    do_ack(v);
    chk("R12", "level vector", 32'(v), 32'h35);
    wr_reg(1'b0, 8'h65);
    step();
    chk("R12", "level line re-requests", 32'(int_out), 1);
    do_ack(v);
    chk("R12", "level second vector", 32'(v), 32'h35);
    irq_lines[5] = 1'b0;
    step();
    wr_reg(1'b0, 8'h65);
    step();
    chk("R12", "level withdrawn", 32'(int_out), 0);
    irq_level = '0;

    // restart with automatic end of interrupt
    wr_reg(1'b0, 8'h0B);
    wr_reg(1'b0, 8'h11);
    irq_lines[2] = 1'b1;
    step(3);
    chk("R2", "int_out low during init", 32'(int_out), 0);
    irq_lines[2] = 1'b0;
    wr_reg(1'b1, 8'h38);
    wr_reg(1'b1, 8'h02);
    chk("R4", "slave cascade byte", 32'(casc_word), 32'h02);
    wr_reg(1'b1, 8'h03);
    step(2);
    rd_reg(1'b0, d);
    chk("R5", "init selects request reg", 32'(d), 0);
    for (int n = 0; n < 8; n++) begin
      irq_lines[n] = 1'b1;
      step(2);
      do_ack(v);
      chk("R3", "auto-eoi vector", 32'(v), 32'h38 + n);
      rd_svc(d);
      chk("R10", "auto-eoi no in-service", 32'(d), 0);
      wr_reg(1'b0, 8'h0A);
      irq_lines[n] = 1'b0;
      step(2);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule